// File: doc/BRIEF.md
# Iterative Euler Step Engine for a Second-Order Equation

The engine integrates a second-order differential equation held as three state values: the independent variable `x`, the solution `y` and its derivative `u`. A single-cycle `start` pulse captures the initial state, the step size `dx` and the bound `a`. The engine then applies forward-Euler steps for as long as `x` stays below `a`. When the bound check fails, the current `y` appears on `yOut` and `done` is raised.

The update is not built as one wide combinational expression. A fixed pool of two multipliers (two-cycle latency) and two single-cycle adder/comparator units is shared over a static schedule of control steps. A control FSM issues that schedule to the datapath through a small bundle of strobes. Every operation starts only once its operands have been produced. All arithmetic is 16-bit two's complement, and every product and sum is truncated to 16 bits.

Top module: `diffeq_engine`

## Requirements
- R1: While reset is held and directly after it, `done` is 0 and `yOut` is 0.
- R2: Each iteration computes x' = x + dx, u' = u − 3·x·u·dx − 3·y·dx and y' = y + u·dx, all modulo 2^16. The three new values replace x, u and y in the same cycle, so every right-hand side uses the old values.
- R3: The bound check compares x and a as signed 16-bit numbers. Iterations continue while x < a. When the check fails, the current y is the result.
- R4: If x ≥ a when the inputs are loaded, no update takes place and the result is the loaded y.
- R5: The start pulse is captured at clock edge E. With N iterations, `done` is high exactly in the cycle that follows edge E + 8·N + 1. Each iteration occupies 8 cycles: one compare, then three rounds of two-cycle multiplies overlapped with single-cycle adds, and at no step do more than two multipliers or two adder units work.
- R6: `done` is a one-cycle pulse. While it is high, `yOut` carries the result.
- R7: A start pulse reloads all inputs and restarts the computation even while an earlier run is in progress. `done` is 0 in the cycle after the pulse, and the abandoned run produces no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load inputs and begin a run |
| xIn | input | 16 | Initial x (signed) |
| yIn | input | 16 | Initial y (signed) |
| uIn | input | 16 | Initial u (signed) |
| dxIn | input | 16 | Step size (signed) |
| aIn | input | 16 | Bound on x (signed) |
| yOut | output | 16 | Current y; holds the result while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a restart that lands in the middle of an iteration, when a multiplier still holds a half-finished product that must not leak into the new run. The bench reaches it by launching a long run and, thirteen cycles later, firing a second start with different inputs. It then checks on every clock that only the second run's `done` and result appear. Signed ordering of the bound check is reached with a negative starting x. Truncation is reached with large u and y, so that the products wrap.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;

  // Strobes issued by the control FSM to the datapath for one control step.
  typedef struct packed {
    logic load;    // capture inputs, flush multipliers
    logic cmp;     // bound check step (comparator unit)
    logic issueA;  // start 3*x and u*dx
    logic issueB;  // start (3x)*(u dx) and 3*y
    logic issueC;  // start (3y)*dx
    logic addX;    // x + dx
    logic addY;    // y + u*dx
    logic subA;    // u - 3xudx
    logic subB;    // (u - 3xudx) - 3ydx, then commit
  } strobe_t;

endpackage

// File: rtl/diffeq_mul.sv
module diffeq_mul #(
  parameter int W   = 16,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         go,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic [W-1:0] res
);

  localparam int CW = $clog2(LAT) + 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  aQ;
  logic [W-1:0]  bQ;

  initial begin
    if (LAT < 2) $error("diffeq_mul: LAT must be at least 2");
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      aQ  <= '0;
      bQ  <= '0;
      res <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else if (go) begin
      aQ  <= opA;
      bQ  <= opB;
      cnt <= CW'(LAT - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) res <= W'(aQ * bQ);
    end
  end

  assign busy = (cnt != '0);

  AST_MUL_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);  // R5
  AST_MUL_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !flush) |=> busy);  // R5

endmodule

// File: rtl/diffeq_ctrl.sv
module diffeq_ctrl
  import diffeq_pkg::*;
#(
  parameter int MUL_LAT = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    xBelow,
  output strobe_t strb,
  output logic    done
);

  localparam int STEP_B = 1 + MUL_LAT;
  localparam int STEP_C = 1 + 2 * MUL_LAT;
  localparam int LAST   = 1 + 3 * MUL_LAT;
  localparam int SW     = $clog2(LAST + 1);

  typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_FIN } state_t;

  state_t        state;
  logic [SW-1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else if (start) begin
      state <= ST_RUN;
      step  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (step == '0 && !xBelow) state <= ST_FIN;
          else if (step == SW'(LAST)) step <= '0;
          else step <= step + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb      = '0;
    strb.load = start;
    if (!start && state == ST_RUN) begin
      strb.cmp    = (step == '0);
      strb.issueA = (step == SW'(1));
      strb.addX   = (step == SW'(1));
      strb.issueB = (step == SW'(STEP_B));
      strb.addY   = (step == SW'(STEP_B));
      strb.issueC = (step == SW'(STEP_C));
      strb.subA   = (step == SW'(STEP_C));
      strb.subB   = (step == SW'(LAST));
    end
  end

  assign done = (state == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);  // R7

endmodule

// File: rtl/diffeq_dp.sv
module diffeq_dp
  import diffeq_pkg::*;
#(
  parameter int W       = 16,
  parameter int MUL_LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      strb,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] uIn,
  input  logic [W-1:0] dxIn,
  input  logic [W-1:0] aIn,
  output logic         xBelow,
  output logic [W-1:0] yRes
);

  localparam int NMUL = 2;
  localparam logic [W-1:0] THREE = W'(3);

  logic [W-1:0] xR, yR, uR, dxR, aR;
  logic [W-1:0] x1R, y1R, tR;
  logic [W-1:0] aluOut;

  logic         mulGo   [NMUL];
  logic [W-1:0] mulA    [NMUL];
  logic [W-1:0] mulB    [NMUL];
  logic [W-1:0] mulRes  [NMUL];
  logic         mulBusy [NMUL];

  // Operand steering for the shared multipliers.
  always_comb begin
    mulGo[0] = strb.issueA | strb.issueB;
    mulA[0]  = strb.issueB ? mulRes[0] : xR;
    mulB[0]  = strb.issueB ? mulRes[1] : THREE;
    mulGo[1] = strb.issueA | strb.issueB | strb.issueC;
    mulA[1]  = strb.issueA ? uR : (strb.issueB ? yR : mulRes[1]);
    mulB[1]  = strb.issueB ? THREE : dxR;
  end

  for (genvar gi = 0; gi < NMUL; gi++) begin : g_mul
    diffeq_mul #(.W(W), .LAT(MUL_LAT)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (strb.load),
      .go    (mulGo[gi]),
      .opA   (mulA[gi]),
      .opB   (mulB[gi]),
      .busy  (mulBusy[gi]),
      .res   (mulRes[gi])
    );
  end

  // Shared adder/subtractor unit.
  always_comb begin
    if (strb.addX)      aluOut = xR + dxR;
    else if (strb.addY) aluOut = yR + mulRes[1];
    else if (strb.subA) aluOut = uR - mulRes[0];
    else if (strb.subB) aluOut = tR - mulRes[1];
    else                aluOut = '0;
  end

  // Comparator unit.
  assign xBelow = ($signed(xR) < $signed(aR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xR  <= '0;
      yR  <= '0;
      uR  <= '0;
      dxR <= '0;
      aR  <= '0;
      x1R <= '0;
      y1R <= '0;
      tR  <= '0;
    end else if (strb.load) begin
      xR  <= xIn;
      yR  <= yIn;
      uR  <= uIn;
      dxR <= dxIn;
      aR  <= aIn;
    end else begin
      if (strb.addX) x1R <= aluOut;
      if (strb.addY) y1R <= aluOut;
      if (strb.subA) tR  <= aluOut;
      if (strb.subB) begin
        xR <= x1R;
        yR <= y1R;
        uR <= aluOut;
      end
    end
  end

  assign yRes = yR;

  AST_OPERANDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.issueB || strb.issueC || strb.subA || strb.subB) |-> (!mulBusy[0] && !mulBusy[1]));  // R2
  AST_ADDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strb.cmp, strb.addX, strb.addY, strb.subA, strb.subB}) <= 2);  // R5
  AST_COMMIT_HOLDS_X: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.subB) |=> $stable(xR));  // R2

endmodule

// File: rtl/diffeq_engine.sv
module diffeq_engine
  import diffeq_pkg::*;
#(
  parameter int W       = 16,
  parameter int MUL_LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  input  logic [W-1:0] uIn,
  input  logic [W-1:0] dxIn,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] yOut,
  output logic         done
);

  strobe_t strb;
  logic    xBelow;

  diffeq_ctrl #(.MUL_LAT(MUL_LAT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .xBelow (xBelow),
    .strb   (strb),
    .done   (done)
  );

  diffeq_dp #(.W(W), .MUL_LAT(MUL_LAT)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .xIn    (xIn),
    .yIn    (yIn),
    .uIn    (uIn),
    .dxIn   (dxIn),
    .aIn    (aIn),
    .xBelow (xBelow),
    .yRes   (yOut)
  );

endmodule

// File: tb/test_diffeq_engine.sv
module test_diffeq_engine;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] xIn = '0, yIn = '0, uIn = '0, dxIn = '0, aIn = '0;
  logic [W-1:0] yOut;
  logic         done;

  diffeq_engine i_diffeq_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .xIn(xIn), .yIn(yIn), .uIn(uIn), .dxIn(dxIn), .aIn(aIn),
    .yOut(yOut), .done(done)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nRun = 0;
  int nFail = 0;
  bit monOn = 0;
  bit armed = 0;
  int doneEdge = 0;
  logic [W-1:0] yExp = '0;
  string caseTag = "";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Software reference loop: count iterations and final y.
  function automatic void refRun(input logic signed [W-1:0] x0, y0, u0, dx0, a0,
                                 output int n, output logic [W-1:0] yf);
    logic signed [W-1:0] x, y, u, dx, a, x1, y1, u1;
    x = x0; y = y0; u = u0; dx = dx0; a = a0;
    n = 0;
    while (x < a && n < 5000) begin
      x1 = W'(x + dx);
      u1 = W'(u - 3 * x * u * dx - 3 * y * dx);
      y1 = W'(y + u * dx);
      x = x1; u = u1; y = y1;
      n++;
    end
    yf = y;
  endfunction

  // Per-cycle model of done and result.
  always @(negedge clk) begin
    if (monOn) begin
      bit expDone;
      expDone = armed && (cyc == doneEdge);
      check(done === expDone, "R5 R6", "done level", int'(done), int'(expDone));
      if (expDone)
        check(yOut === yExp, {caseTag, " R3"}, "result y",
              int'($signed(yOut)), int'($signed(yExp)));
    end
  end

  task automatic launch(input int x, y, u, dx, a, input string req);
    int n;
    logic [W-1:0] yf;
    @(negedge clk);
    xIn = W'(x); yIn = W'(y); uIn = W'(u); dxIn = W'(dx); aIn = W'(a);
    start = 1'b1;
    refRun(W'(x), W'(y), W'(u), W'(dx), W'(a), n, yf);
    yExp = yf;
    doneEdge = cyc + 1 + 8 * n + 1;
    caseTag = req;
    armed = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishCase();
    while (cyc <= doneEdge + 1) @(negedge clk);
  endtask

  task automatic runCase(input int x, y, u, dx, a, input string req);
    launch(x, y, u, dx, a, req);
    finishCase();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1", "done in reset", int'(done), 0);
    check(yOut === '0, "R1", "yOut in reset", int'(yOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);
    check(yOut === '0, "R1", "yOut after reset", int'(yOut), 0);
    monOn = 1'b1;

    // R4: bound already reached at load
    runCase(10, 77, 5, 1, 10, "R4");
    runCase(12, -9, 3, 2, 5, "R4");
    // R2: single iteration, y' = 5 + 2*1 = 7
    runCase(0, 5, 2, 1, 1, "R2");
    // R3: signed ordering with negative x
    runCase(-5, 7, -2, 2, 3, "R3");
    // R2: large values so that products wrap
    runCase(0, 1000, 300, 4, 8, "R2");
    // R7: restart mid-run; only the second run may complete
    launch(0, 3, 1, 1, 40, "R7");
    repeat (13) @(negedge clk);
    launch(1, -4, 6, 3, 13, "R7");
    finishCase();
    // R2: random small inputs
    for (int k = 0; k < 30; k++) begin
      int x, a;
      x = int'($urandom_range(40)) - 20;
      a = x + int'($urandom_range(43)) - 3;
      runCase(x, int'($urandom_range(100)) - 50, int'($urandom_range(100)) - 50,
              int'($urandom_range(4, 1)), a, "R2");
    end
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule